// File: doc/BRIEF.md
# Queued SPI Master with Command Queue

This block is an SPI master that runs a queue of byte transfers with no processor work per byte. Software uses a simple register bus to fill a transmit store and a per-entry command store. It then selects a range of queue entries with a first-entry pointer and a last-entry pointer, and sets a run bit. The engine then steps through the selected entries in order. For each entry it shifts one byte out, captures the byte returned by the peripheral into a receive store, and drives the single chip select as each entry's command word directs.

When the last selected entry has finished, the engine clears the run bit and sets a done flag. Software polls the run bit until it reads 0, then reads the received bytes. A hold mode, armed by a control bit together with a lock register, keeps chip select low after the final entry. A second queue run can then extend the same SPI transaction, and clearing the lock releases chip select.

Top module: `qspi_queue_master`

## Requirements
- R1: After reset, chip select is high, SCK is low, the control register reads 0, the status register reads 0, and the divider reads 1.
- R2: A run sends the entries from the first pointer (address 0x32) through the last pointer (address 0x33) inclusive, in ascending order. It uses SPI mode 0: MOSI changes on falling SCK, MISO is sampled on rising SCK, and the MSB goes first. The shifter is busy only while the run bit is set.
- R3: The transmit byte of entry i is written to and read back from word 2*i. The byte received during the most recent run of entry i is read from word 2*i+1. Command entry i sits at address 0x20+i.
- R4: Writing 1 to control bit 0 (address 0x30) starts a run. When the last entry has finished, bit 0 reads 0 and status bit 0 (address 0x31) reads 1. Writing 0 to the status register clears that bit.
- R5: Command bit 1 (continue) keeps chip select low from that entry into the next one. If bit 1 is clear, chip select rises for half an SCK period before the next entry starts. Chip select never changes while a byte is being shifted.
- R6: If control bit 1 and lock bit 0 (address 0x34) are both 1, chip select stays low after the last entry and across the next run. Writing 0 to the lock releases chip select.
- R7: While the run bit is 1, writes to the transmit store, the command store, both pointers, the divider and the control register are ignored.
- R8: SCK half period is D system clocks, where D is the divider value (address 0x35). A value of 0 acts as 1, so SCK is never faster than half the system clock.
- R9: Command bit 3 (lead delay) adds one extra half period between the start of the entry and its first rising SCK edge.
- R10: Command bit 2 (no select) keeps chip select high for that entry while its byte is still clocked. Command bit 0 is reserved and reads 0.
- R11: SCK is low whenever the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Two cases are hard to reach from the ports. The first is a register write that lands in the middle of a run. The bench slows SCK with a large divider so that a single byte lasts hundreds of clocks. It then writes the transmit store, a command entry and the first pointer while the run bit is still set, and afterwards reads them back and compares the bytes the peripheral model captured. The second is chip select held across two separate runs. The bench counts falling edges of chip select across two back-to-back runs with hold armed, and checks that only one falling edge occurs before the lock is cleared.

// File: rtl/qspi_pkg.sv
// Shared sizes, address map and command word layout for the queued SPI master.
// Assumes at least 8 queue entries, so the register page fits in the low address bits.
package qspi_pkg;
    parameter int unsigned QN   = 16;
    parameter int unsigned DIVW = 8;
    localparam int unsigned IW  = $clog2(QN);
    localparam int unsigned AW  = IW + 2;
    localparam int unsigned DW  = 8;

    // Register page selectors, low three address bits when addr[AW-1:AW-2] == 2'b11
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_STAT  = 3'd1;
    localparam logic [2:0] SEL_FIRST = 3'd2;
    localparam logic [2:0] SEL_LAST  = 3'd3;
    localparam logic [2:0] SEL_LOCK  = 3'd4;
    localparam logic [2:0] SEL_DIV   = 3'd5;

    // Command entry, stored as write-data bits [3:1]; bit 0 is reserved
    typedef struct packed {
        logic lead;    // bit 3: extra half period before first edge
        logic no_sel;  // bit 2: keep chip select high for this entry
        logic cont;    // bit 1: keep chip select low into next entry
    } cmd_t;
endpackage

// File: rtl/qspi_regs.sv
// Register file and queue stores: transmit, command and receive stores, pointers,
// control, status, lock and divider. Assumes one register access per cycle and a
// combinational read path. Most writes are refused while a run is active.
module qspi_regs
    import qspi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [IW-1:0]   cur_idx,
    output logic [7:0]      cur_tx,
    output cmd_t            cur_cmd,
    input  logic            rx_we,
    input  logic [7:0]      rx_byte,
    input  logic            finish,
    output logic            go,
    output logic            spe,
    output logic            hold_after,
    output logic            lock,
    output logic [IW-1:0]   first_ptr,
    output logic [IW-1:0]   last_ptr,
    output logic [DIVW-1:0] div
);
    logic [7:0] tx_mem [QN];
    logic [7:0] rx_mem [QN];
    cmd_t       cmd_mem [QN];
    logic       done;

    logic          in_data, in_cmd, in_reg;
    logic [IW-1:0] data_idx, cmd_idx;
    logic [2:0]    sel;

    // Decode the address into store windows and register selectors
    always_comb begin
        in_data  = !addr[AW-1];
        in_cmd   = (addr[AW-1:AW-2] == 2'b10);
        in_reg   = (addr[AW-1:AW-2] == 2'b11);
        data_idx = addr[IW:1];
        cmd_idx  = addr[IW-1:0];
        sel      = addr[2:0];
        go       = wr_en && in_reg && (sel == SEL_CTRL) && !spe && wdata[0];
        cur_tx   = tx_mem[cur_idx];
        cur_cmd  = cmd_mem[cur_idx];
    end

    // Register and store updates, with run-time write protection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QN; i++) begin
                tx_mem[i]  <= '0;
                rx_mem[i]  <= '0;
                cmd_mem[i] <= '0;
            end
            first_ptr  <= '0;
            last_ptr   <= '0;
            spe        <= 1'b0;
            hold_after <= 1'b0;
            done       <= 1'b0;
            lock       <= 1'b0;
            div        <= DIVW'(1);
        end else begin
            if (rx_we)
                rx_mem[cur_idx] <= rx_byte;
            if (finish) begin
                spe  <= 1'b0;
                done <= 1'b1;
            end else if (wr_en && in_reg && sel == SEL_STAT && !wdata[0]) begin
                done <= 1'b0;
            end
            if (wr_en && in_reg && sel == SEL_LOCK)
                lock <= wdata[0];
            if (wr_en && !spe) begin
                if (in_data && !addr[0])
                    tx_mem[data_idx] <= wdata;
                if (in_cmd)
                    cmd_mem[cmd_idx] <= cmd_t'(wdata[3:1]);
                if (in_reg) begin
                    case (sel)
                        SEL_CTRL:  begin spe <= wdata[0]; hold_after <= wdata[1]; end
                        SEL_FIRST: first_ptr <= wdata[IW-1:0];
                        SEL_LAST:  last_ptr  <= wdata[IW-1:0];
                        SEL_DIV:   div       <= wdata;
                        default:   ;
                    endcase
                end
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (in_data)
            rdata = addr[0] ? rx_mem[data_idx] : tx_mem[data_idx];
        else if (in_cmd)
            rdata = DW'({cmd_mem[cmd_idx], 1'b0});
        else if (in_reg) begin
            case (sel)
                SEL_CTRL:  rdata = DW'({hold_after, spe});
                SEL_STAT:  rdata = DW'(done);
                SEL_FIRST: rdata = DW'(first_ptr);
                SEL_LAST:  rdata = DW'(last_ptr);
                SEL_LOCK:  rdata = DW'(lock);
                SEL_DIV:   rdata = div;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/qspi_shifter.sv
// Byte shifter for SPI mode 0, MSB first. Assumes half >= 1. Loads a byte on
// start, clocks eight bits and raises done for one cycle after the last falling edge.
module qspi_shifter
    import qspi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            lead,
    input  logic [7:0]      tx,
    input  logic [DIVW-1:0] half,
    input  logic            miso,
    output logic            sck,
    output logic            mosi,
    output logic            busy,
    output logic            done,
    output logic [7:0]      rx
);
    logic [DIVW-1:0] cnt;
    logic [2:0]      bitn;
    logic [7:0]      sh;
    logic            lead_q;

    // Half-period timing, edge generation and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; bitn <= '0; sh <= '0; rx <= '0;
            lead_q <= 1'b0; sck <= 1'b0; busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                busy   <= 1'b1;
                sh     <= tx;
                cnt    <= '0;
                bitn   <= '0;
                lead_q <= lead;
                sck    <= 1'b0;
            end else if (busy) begin
                if (cnt == half - DIVW'(1)) begin
                    cnt <= '0;
                    if (lead_q)
                        lead_q <= 1'b0;
                    else if (!sck) begin
                        sck <= 1'b1;
                        rx  <= {rx[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + DIVW'(1);
                end
            end
        end
    end

    // MOSI presents the current MSB
    always_comb mosi = sh[7];
endmodule

// File: rtl/qspi_sequencer.sv
// Queue walker and chip-select control. Steps from the first pointer to the last
// pointer (wrapping), starts the shifter per entry, and holds or releases chip select
// from the continue bit and the hold/lock pair. Assumes half >= 1.
module qspi_sequencer
    import qspi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [IW-1:0]   first_ptr,
    input  logic [IW-1:0]   last_ptr,
    input  cmd_t            cmd,
    input  logic            hold_after,
    input  logic            lock,
    input  logic [DIVW-1:0] half,
    input  logic            shf_done,
    output logic [IW-1:0]   ptr,
    output logic            shf_start,
    output logic            shf_lead,
    output logic            rx_we,
    output logic            finish,
    output logic            idle,
    output logic            cs_n
);
    typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_GAP} state_t;
    state_t          st;
    logic            cs_on;
    logic [DIVW-1:0] gcnt;
    logic            keep;

    // Strobes derived from the current state
    always_comb begin
        shf_start = (st == S_LAUNCH);
        shf_lead  = cmd.lead;
        rx_we     = (st == S_WAIT) && shf_done;
        finish    = rx_we && (ptr == last_ptr);
        idle      = (st == S_IDLE);
        keep      = hold_after && lock;
        cs_n      = !cs_on;
    end

    // Queue stepping and chip-select state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; ptr <= '0; cs_on <= 1'b0; gcnt <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (go) begin
                        ptr <= first_ptr;
                        st  <= S_LAUNCH;
                    end else if (cs_on && !keep) begin
                        cs_on <= 1'b0;
                    end
                end
                S_LAUNCH: begin
                    cs_on <= !cmd.no_sel;
                    st    <= S_WAIT;
                end
                S_WAIT: begin
                    if (shf_done) begin
                        if (ptr == last_ptr) begin
                            st <= S_IDLE;
                            if (!keep)
                                cs_on <= 1'b0;
                        end else begin
                            ptr <= ptr + IW'(1);
                            if (cmd.cont)
                                st <= S_LAUNCH;
                            else begin
                                cs_on <= 1'b0;
                                gcnt  <= '0;
                                st    <= S_GAP;
                            end
                        end
                    end
                end
                S_GAP: begin
                    if (gcnt == half - DIVW'(1))
                        st <= S_LAUNCH;
                    else
                        gcnt <= gcnt + DIVW'(1);
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qspi_queue_master.sv
// Top level of the queued SPI master: register file, queue sequencer and byte shifter.
// Assumes a single chip select and SPI mode 0.
module qspi_queue_master
    import qspi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          spi_cs_n
);
    logic            go, spe_q, hold_after, lock, rx_we, seq_finish, seq_idle;
    logic            shf_start, shf_lead, shf_busy, shf_done;
    logic [IW-1:0]   first_ptr, last_ptr, ptr;
    logic [DIVW-1:0] div, half;
    logic [7:0]      cur_tx, rx_byte;
    cmd_t            cur_cmd;

    // Clamp the divider so the half period is at least one clock
    always_comb half = (div == '0) ? DIVW'(1) : div;

    qspi_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cur_idx(ptr), .cur_tx(cur_tx),
        .cur_cmd(cur_cmd), .rx_we(rx_we), .rx_byte(rx_byte), .finish(seq_finish),
        .go(go), .spe(spe_q), .hold_after(hold_after), .lock(lock),
        .first_ptr(first_ptr), .last_ptr(last_ptr), .div(div)
    );

    qspi_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .first_ptr(first_ptr),
        .last_ptr(last_ptr), .cmd(cur_cmd), .hold_after(hold_after), .lock(lock),
        .half(half), .shf_done(shf_done), .ptr(ptr), .shf_start(shf_start),
        .shf_lead(shf_lead), .rx_we(rx_we), .finish(seq_finish), .idle(seq_idle),
        .cs_n(spi_cs_n)
    );

    qspi_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .start(shf_start), .lead(shf_lead),
        .tx(cur_tx), .half(half), .miso(spi_miso), .sck(spi_sck),
        .mosi(spi_mosi), .busy(shf_busy), .done(shf_done), .rx(rx_byte)
    );
endmodule

// File: rtl/qspi_queue_checker.sv
// Protocol checks for the queued SPI master, bound to the top level.
module qspi_queue_checker
    import qspi_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          sck,
    input logic          cs_n,
    input logic          spe,
    input logic          finish,
    input logic          busy,
    input logic          seq_idle,
    input logic [IW-1:0] first_ptr
);
    assert_idle_sck_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idle |-> !sck);
    assert_finish_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!spe));
    assert_cs_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n));
    assert_ptr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spe && $past(spe)) |-> $stable(first_ptr));
    assert_busy_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> spe);
endmodule

bind qspi_queue_master qspi_queue_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .spe(spe_q),
    .finish(seq_finish), .busy(shf_busy), .seq_idle(seq_idle), .first_ptr(first_ptr)
);

// File: tb/tb_qspi_queue_master.sv
`timescale 1ns/1ps
module tb_qspi_queue_master;
    logic       clk = 0, rst_n = 0, reg_wr = 0, miso;
    logic [5:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       sck, mosi, cs_n;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    localparam logic [5:0] A_CTRL = 6'h30, A_STAT = 6'h31, A_FIRST = 6'h32,
                           A_LAST = 6'h33, A_LOCK = 6'h34, A_DIV = 6'h35;

    qspi_queue_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    always #5 clk = ~clk;

    // Peripheral model: logs MOSI bytes while selected, returns a known MISO pattern
    logic [7:0] mlog [64];
    int nlog = 0, bitc = 0, nfall = 0, nrise = 0;
    logic [7:0] cap = 0, rcur;
    realtime tfall = 0, trise [2];

    function automatic logic [7:0] resp(int k);
        return 8'h5A ^ 8'(k * 37);
    endfunction

    always_comb rcur = resp(nlog);
    assign miso = rcur[3'(7 - bitc)];

    always @(posedge sck) begin
        if (nrise < 2) trise[nrise] = $realtime;
        nrise++;
        if (!cs_n) begin
            cap = {cap[6:0], mosi};
            if (bitc == 7) begin
                if (nlog < 64) mlog[nlog] = cap;
                nlog++;
                bitc = 0;
            end else bitc++;
        end
    end
    always @(posedge cs_n) bitc = 0;
    always @(negedge cs_n) begin nfall++; tfall = $realtime; end

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        for (int i = 0; i < 60000; i++) begin
            rd(A_CTRL, c);
            if (!c[0]) return;
        end
    endtask

    task automatic run(logic [7:0] ctrl);
        nrise = 0;
        wr(A_CTRL, ctrl);
        wait_idle();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
        rd(A_DIV, d);  chk("R1 div", d, 1);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sck", sck, 0);
    endtask

    task automatic t_basic();
        logic [7:0] d, txb [3];
        int n0, f0;
        txb = '{8'h3C, 8'h81, 8'hF0};
        wr(A_DIV, 1);
        for (int i = 0; i < 3; i++) begin
            wr(6'(2 * i), txb[i]);
            wr(6'h20 + 6'(i), (i < 2) ? 8'h02 : 8'h00);
        end
        wr(A_FIRST, 0); wr(A_LAST, 2);
        n0 = nlog; f0 = nfall;
        run(8'h01);
        chk("R2 byte count", nlog - n0, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R2 mosi byte", mlog[n0 + i], txb[i]);
            rd(6'(2 * i + 1), d); chk("R3 rx word", d, resp(n0 + i));
            rd(6'(2 * i), d);     chk("R3 tx word", d, txb[i]);
        end
        chk("R5 one select", nfall - f0, 1);
        chk("R5 released", cs_n, 1);
        chk("R11 sck idle", sck, 0);
        rd(A_CTRL, d); chk("R4 run bit cleared", d[0], 0);
        rd(A_STAT, d); chk("R4 done set", d, 1);
        wr(A_STAT, 0);
        rd(A_STAT, d); chk("R4 done cleared", d, 0);
        rd(6'h20, d);  chk("R10 reserved bit reads 0", d, 8'h02);
    endtask

    task automatic t_split();
        int n0, f0;
        wr(0, 8'h11); wr(2, 8'h22); wr(6'h20, 0); wr(6'h21, 0);
        wr(A_FIRST, 0); wr(A_LAST, 1);
        n0 = nlog; f0 = nfall;
        run(8'h01);
        chk("R5 two selects", nfall - f0, 2);
        chk("R2 split byte0", mlog[n0], 8'h11);
        chk("R2 split byte1", mlog[n0 + 1], 8'h22);
    endtask

    task automatic t_first_ptr();
        logic [7:0] d;
        int n0;
        wr(10, 8'hA1); wr(12, 8'hB2); wr(6'h25, 8'h02); wr(6'h26, 0);
        wr(A_FIRST, 5); wr(A_LAST, 6);
        n0 = nlog;
        run(8'h01);
        chk("R2 range count", nlog - n0, 2);
        chk("R2 range byte5", mlog[n0], 8'hA1);
        chk("R2 range byte6", mlog[n0 + 1], 8'hB2);
        rd(11, d); chk("R3 rx entry5", d, resp(n0));
        rd(13, d); chk("R3 rx entry6", d, resp(n0 + 1));
    endtask

    task automatic t_hold();
        int f0;
        wr(0, 8'h77); wr(6'h20, 0); wr(A_FIRST, 0); wr(A_LAST, 0);
        wr(A_LOCK, 1);
        f0 = nfall;
        run(8'h03);
        chk("R6 held after run", cs_n, 0);
        run(8'h03);
        chk("R6 single select over two runs", nfall - f0, 1);
        chk("R6 still held", cs_n, 0);
        wr(A_LOCK, 0);
        repeat (3) @(negedge clk);
        chk("R6 released by lock", cs_n, 1);
        wr(A_CTRL, 0);
    endtask

    task automatic t_ignore();
        logic [7:0] d;
        int n0;
        wr(A_DIV, 40);
        wr(0, 8'h5C); wr(2, 8'h6D); wr(6'h20, 8'h02); wr(6'h21, 0);
        wr(A_FIRST, 0); wr(A_LAST, 1);
        n0 = nlog;
        wr(A_CTRL, 1);
        repeat (30) @(negedge clk);
        wr(0, 8'hEE); wr(A_FIRST, 7); wr(6'h20, 0); wr(A_DIV, 2);
        wait_idle();
        rd(0, d);       chk("R7 tx kept", d, 8'h5C);
        rd(A_FIRST, d); chk("R7 pointer kept", d, 0);
        rd(6'h20, d);   chk("R7 cmd kept", d, 8'h02);
        rd(A_DIV, d);   chk("R7 div kept", d, 40);
        chk("R7 bytes sent", mlog[n0], 8'h5C);
        chk("R7 bytes sent 2", mlog[n0 + 1], 8'h6D);
    endtask

    task automatic t_div();
        wr(0, 8'h0F); wr(6'h20, 0); wr(A_FIRST, 0); wr(A_LAST, 0);
        wr(A_DIV, 3);
        run(8'h01);
        chk("R8 period div3", int'(trise[1] - trise[0]), 60);
        wr(A_DIV, 0);
        run(8'h01);
        chk("R8 period div0", int'(trise[1] - trise[0]), 20);
    endtask

    task automatic t_lead();
        wr(A_DIV, 2); wr(0, 8'hC3); wr(6'h20, 0); wr(A_FIRST, 0); wr(A_LAST, 0);
        run(8'h01);
        chk("R9 no lead", int'(trise[0] - tfall), 20);
        wr(6'h20, 8'h08);
        run(8'h01);
        chk("R9 with lead", int'(trise[0] - tfall), 40);
    endtask

    task automatic t_nosel();
        int n0, f0;
        wr(A_DIV, 1);
        wr(0, 8'h99); wr(2, 8'h42); wr(6'h20, 8'h04); wr(6'h21, 0);
        wr(A_FIRST, 0); wr(A_LAST, 1);
        n0 = nlog; f0 = nfall;
        run(8'h01);
        chk("R10 only selected byte seen", nlog - n0, 1);
        chk("R10 selected byte", mlog[n0], 8'h42);
        chk("R10 one select", nfall - f0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_split();
        t_first_ptr();
        t_hold();
        t_ignore();
        t_div();
        t_lead();
        t_nosel();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule